// File: doc/BRIEF.md
# Streaming Remote Line Prefetch Buffer

This block sits beside a processing core and serves that core's read-only loads to memory owned by another node. Each load that misses asks memory for its own line first and then for a fixed number of the lines that follow it. The lines are kept in a handful of blocks so that a streaming reader finds its next words already on chip. Memory answers each line request with a whole line, tagged by the block slot that asked for it, and answers may return in any order.

The buffer never writes anything back, because it only ever holds copies of data it has read. It does not track changes that other agents make to the lines it holds. Software keeps it correct by pulsing a flush input at synchronization points, such as barriers, which drops every held line. A flush that arrives while line requests are still outstanding marks their blocks so the late data is thrown away on arrival, and a load caught by the flush starts its lookup again.

Top module: `remote_line_prefetch_buf`

## Requirements
- R1: After reset the core port is ready (`ldReady` high), no memory request is raised and no load response is given; every block is empty, so the first load misses.
- R2: A load that misses issues a request for its own line first, then one request for each of the next `PF_LINES` sequential lines in ascending order. The line number is the load address divided by `LINE_BYTES`. It answers with the 32-bit word selected by address bits [5:2], where word k of a returned line occupies bits [32k+31:32k] of `memRspData`.
- R3: A load whose line is held with its data present is answered without a memory request for that line.
- R4: A load whose line has a request in flight issues no second request for it; it waits and answers once that fill arrives.
- R5: Fills may return in any order; each is written to the block named by `memRspSlot`, and that block must have a fill in flight.
- R6: No line is held in two blocks, and a prefetch line already held (present or in flight) is not requested again.
- R7: A new line goes to an empty block if there is one, otherwise to the least recently used block with data present; blocks with a fill in flight are never chosen, and a recently loaded line survives while older lines are replaced.
- R8: Held data is not kept coherent: a load that hits returns the buffered value even after memory has changed.
- R9: A one-cycle `flush` pulse invalidates every block, so later loads fetch fresh data.
- R10: Fills outstanding at a flush are discarded when they return, their blocks stay unusable until then, and a load in progress at the flush restarts and returns fresh data.
- R11: When every block has a fill in flight, a demand miss raises no memory request and stalls until a block becomes free.
- R12: Each accepted load yields exactly one `rspValid` pulse one cycle wide, and `ldReady` stays low from acceptance until that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | One-cycle pulse that drops every held line |
| ldValid | input | 1 | Core load request valid |
| ldReady | output | 1 | Buffer can accept a load |
| ldAddr | input | ADDR_W | Byte address of the load |
| rspValid | output | 1 | Load response valid, one cycle |
| rspData | output | WORD_W | Loaded word |
| memReqValid | output | 1 | Line read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqLine | output | ADDR_W-log2(LINE_BYTES) | Line number requested |
| memReqSlot | output | log2(NUM_BLOCKS) | Block slot that will receive the line |
| memRspValid | input | 1 | Line fill valid |
| memRspSlot | input | log2(NUM_BLOCKS) | Block slot the fill belongs to |
| memRspData | input | LINE_BYTES*8 | Whole line of data |

## Verification
On every cycle the assertions check the block table: a fill only lands on a block that waits for one, no line is held twice, replacement never picks a block with a fill in flight, a flush leaves nothing live, and responses and the ready signal follow the one-load-at-a-time pattern. Ordering and content behaviour only the bench scenarios can show. These cover demand-then-prefetch request order, which line least-recent-use replacement drops, the stale value returned after memory changes, and the absence of duplicate requests while a fill is pending. They also cover discarding of fills overtaken by a flush and the stall when every block is waiting.

// File: rtl/rlpb_pkg.sv
package rlpb_pkg;

  typedef enum logic [1:0] {
    BLK_EMPTY,
    BLK_PEND,
    BLK_VALID,
    BLK_STALE
  } blkState_e;

  typedef enum logic [1:0] {
    C_IDLE,
    C_ISSUE,
    C_WAIT,
    C_RESP
  } ctrlState_e;

  typedef struct packed {
    logic touch;
    logic alloc;
    logic capture;
  } ctrlStrobe_t;

  typedef struct packed {
    logic hitAny;
    logic hitReady;
    logic victimOk;
  } dpStatus_t;

endpackage

// File: rtl/rlpb_datapath.sv
module rlpb_datapath
  import rlpb_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int LINE_W     = 26,
  parameter int LINE_BITS  = 512,
  parameter int WORD_W     = 32,
  parameter int WSEL_W     = 4,
  parameter int SLOT_W     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flush,
  input  ctrlStrobe_t          strobe,
  input  logic [LINE_W-1:0]    lookLine,
  input  logic [WSEL_W-1:0]    wordSel,
  output dpStatus_t            status,
  output logic [SLOT_W-1:0]    victimIdx,
  input  logic                 memRspValid,
  input  logic [SLOT_W-1:0]    memRspSlot,
  input  logic [LINE_BITS-1:0] memRspData,
  output logic [WORD_W-1:0]    rspData
);

  blkState_e              st     [NUM_BLOCKS];
  blkState_e              stNext [NUM_BLOCKS];
  logic [LINE_W-1:0]      tag    [NUM_BLOCKS];
  logic [LINE_BITS-1:0]   data   [NUM_BLOCKS];
  logic [SLOT_W-1:0]      age    [NUM_BLOCKS];

  logic [SLOT_W-1:0] hitIdx, touchIdx;
  logic              doTouch;

  // Lookup of the requested line among live blocks
  always_comb begin
    status.hitAny   = 1'b0;
    status.hitReady = 1'b0;
    hitIdx          = '0;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if ((st[i] == BLK_VALID || st[i] == BLK_PEND) && tag[i] == lookLine) begin
        status.hitAny   = 1'b1;
        status.hitReady = (st[i] == BLK_VALID);
        hitIdx          = SLOT_W'(i);
      end
    end
  end

  // Replacement: first empty block, else oldest block holding data
  logic              freeOk, oldOk;
  logic [SLOT_W-1:0] freeIdx, oldIdx, oldAge;
  always_comb begin
    freeOk  = 1'b0;
    freeIdx = '0;
    oldOk   = 1'b0;
    oldIdx  = '0;
    oldAge  = '0;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (st[i] == BLK_EMPTY && !freeOk) begin
        freeOk  = 1'b1;
        freeIdx = SLOT_W'(i);
      end
      if (st[i] == BLK_VALID && (!oldOk || age[i] > oldAge)) begin
        oldOk  = 1'b1;
        oldIdx = SLOT_W'(i);
        oldAge = age[i];
      end
    end
    status.victimOk = freeOk | oldOk;
    victimIdx       = freeOk ? freeIdx : oldIdx;
  end

  // Block state next value: fill, then allocation, then flush
  always_comb begin
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      stNext[i] = st[i];
      if (memRspValid && memRspSlot == SLOT_W'(i))
        stNext[i] = (st[i] == BLK_PEND) ? BLK_VALID : BLK_EMPTY;
      if (strobe.alloc && victimIdx == SLOT_W'(i))
        stNext[i] = BLK_PEND;
      if (flush) begin
        if (stNext[i] == BLK_VALID)     stNext[i] = BLK_EMPTY;
        else if (stNext[i] == BLK_PEND) stNext[i] = BLK_STALE;
      end
    end
  end

  assign doTouch  = strobe.alloc | strobe.touch;
  assign touchIdx = strobe.alloc ? victimIdx : hitIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BLOCKS; i++) begin
        st[i]  <= BLK_EMPTY;
        tag[i] <= '0;
        age[i] <= SLOT_W'(i);
      end
    end else begin
      for (int i = 0; i < NUM_BLOCKS; i++) begin
        st[i] <= stNext[i];
        if (strobe.alloc && victimIdx == SLOT_W'(i)) tag[i] <= lookLine;
        if (doTouch) begin
          if (touchIdx == SLOT_W'(i))     age[i] <= '0;
          else if (age[i] < age[touchIdx]) age[i] <= age[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_BLOCKS; i++)
      if (memRspValid && memRspSlot == SLOT_W'(i) && st[i] == BLK_PEND)
        data[i] <= memRspData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rspData <= '0;
    else if (strobe.capture) rspData <= data[hitIdx][wordSel*WORD_W +: WORD_W];
  end

  // Checking helpers
  logic dupFlag;
  int   liveCnt;
  always_comb begin
    dupFlag = 1'b0;
    liveCnt = 0;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (st[i] == BLK_VALID || st[i] == BLK_PEND) liveCnt++;
      for (int j = i + 1; j < NUM_BLOCKS; j++)
        if ((st[i] == BLK_VALID || st[i] == BLK_PEND) &&
            (st[j] == BLK_VALID || st[j] == BLK_PEND) && tag[i] == tag[j])
          dupFlag = 1'b1;
    end
  end

  // R5
  fill_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> (st[memRspSlot] == BLK_PEND || st[memRspSlot] == BLK_STALE));

  // R6
  no_dup_line_chk: assert property (@(posedge clk) disable iff (!rstN) !dupFlag);

  // R7
  victim_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |-> (st[victimIdx] == BLK_EMPTY || st[victimIdx] == BLK_VALID));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (liveCnt == 0));

endmodule

// File: rtl/rlpb_ctrl.sv
module rlpb_ctrl
  import rlpb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 6,
  parameter int WB_W     = 2,
  parameter int LINE_W   = 26,
  parameter int WSEL_W   = 4,
  parameter int PF_LINES = 1,
  parameter int CNT_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              ldValid,
  output logic              ldReady,
  input  logic [ADDR_W-1:0] ldAddr,
  output logic              rspValid,
  output logic              memReqValid,
  input  logic              memReqReady,
  input  dpStatus_t         status,
  output ctrlStrobe_t       strobe,
  output logic [LINE_W-1:0] lookLine,
  output logic [WSEL_W-1:0] wordSel
);

  ctrlState_e        state, stateN;
  logic [LINE_W-1:0] baseLine, baseN, curLine;
  logic [WSEL_W-1:0] selN;
  logic [CNT_W-1:0]  lineCnt, cntN;
  logic              issueGo, lastLine;

  logic unusedByteBits;
  assign unusedByteBits = ^ldAddr[WB_W-1:0];

  assign curLine  = baseLine + LINE_W'(lineCnt);
  assign lookLine = (state == C_ISSUE) ? curLine : baseLine;
  assign lastLine = (lineCnt == CNT_W'(PF_LINES));
  assign ldReady  = (state == C_IDLE);
  assign rspValid = (state == C_RESP);

  assign memReqValid = (state == C_ISSUE) && !status.hitAny && status.victimOk;

  // A prefetch line without a free block is skipped; the demand line waits
  assign issueGo = status.hitAny || (status.victimOk && memReqReady) ||
                   (!status.victimOk && lineCnt != '0);

  always_comb begin
    strobe.alloc   = memReqValid && memReqReady;
    strobe.touch   = (state == C_ISSUE) && (lineCnt == '0) && status.hitAny;
    strobe.capture = (state == C_WAIT) && !flush && status.hitReady;
  end

  always_comb begin
    stateN = state;
    baseN  = baseLine;
    selN   = wordSel;
    cntN   = lineCnt;
    unique case (state)
      C_IDLE: if (ldValid) begin
        stateN = C_ISSUE;
        baseN  = ldAddr[ADDR_W-1:OFF_W];
        selN   = ldAddr[OFF_W-1:WB_W];
        cntN   = '0;
      end
      C_ISSUE: begin
        if (flush) cntN = '0;
        else if (issueGo) begin
          if (lastLine) stateN = C_WAIT;
          else          cntN   = lineCnt + CNT_W'(1);
        end
      end
      C_WAIT: begin
        if (flush || !status.hitAny) begin
          stateN = C_ISSUE;
          cntN   = '0;
        end else if (status.hitReady) stateN = C_RESP;
      end
      C_RESP: stateN = C_IDLE;
      default: stateN = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= C_IDLE;
      baseLine <= '0;
      wordSel  <= '0;
      lineCnt  <= '0;
    end else begin
      state    <= stateN;
      baseLine <= baseN;
      wordSel  <= selN;
      lineCnt  <= cntN;
    end
  end

  // R12
  ld_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && ldReady) |=> !ldReady);

  // R12
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R11
  stall_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!status.victimOk && !status.hitAny) |-> !memReqValid);

endmodule

// File: rtl/remote_line_prefetch_buf.sv
module remote_line_prefetch_buf
  import rlpb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int WORD_W     = 32,
  parameter int NUM_BLOCKS = 4,
  parameter int PF_LINES   = 1,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int WB_W      = $clog2(WORD_W / 8),
  localparam int LINE_W    = ADDR_W - OFF_W,
  localparam int LINE_BITS = LINE_BYTES * 8,
  localparam int WSEL_W    = OFF_W - WB_W,
  localparam int SLOT_W    = $clog2(NUM_BLOCKS),
  localparam int CNT_W     = $clog2(PF_LINES + 2)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flush,
  input  logic                 ldValid,
  output logic                 ldReady,
  input  logic [ADDR_W-1:0]    ldAddr,
  output logic                 rspValid,
  output logic [WORD_W-1:0]    rspData,
  output logic                 memReqValid,
  input  logic                 memReqReady,
  output logic [LINE_W-1:0]    memReqLine,
  output logic [SLOT_W-1:0]    memReqSlot,
  input  logic                 memRspValid,
  input  logic [SLOT_W-1:0]    memRspSlot,
  input  logic [LINE_BITS-1:0] memRspData
);

  dpStatus_t         status;
  ctrlStrobe_t       strobe;
  logic [LINE_W-1:0] lookLine;
  logic [WSEL_W-1:0] wordSel;

  assign memReqLine = lookLine;

  rlpb_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WB_W(WB_W), .LINE_W(LINE_W),
    .WSEL_W(WSEL_W), .PF_LINES(PF_LINES), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush),
    .ldValid(ldValid), .ldReady(ldReady), .ldAddr(ldAddr),
    .rspValid(rspValid),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .status(status), .strobe(strobe),
    .lookLine(lookLine), .wordSel(wordSel)
  );

  rlpb_datapath #(
    .NUM_BLOCKS(NUM_BLOCKS), .LINE_W(LINE_W), .LINE_BITS(LINE_BITS),
    .WORD_W(WORD_W), .WSEL_W(WSEL_W), .SLOT_W(SLOT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .flush(flush),
    .strobe(strobe), .lookLine(lookLine), .wordSel(wordSel),
    .status(status), .victimIdx(memReqSlot),
    .memRspValid(memRspValid), .memRspSlot(memRspSlot), .memRspData(memRspData),
    .rspData(rspData)
  );

endmodule

// File: tb/tb_remote_line_prefetch_buf.sv
module tb_remote_line_prefetch_buf;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         flush = 1'b0;
  logic         ldValid = 1'b0;
  logic         ldReady;
  logic [31:0]  ldAddr = '0;
  logic         rspValid;
  logic [31:0]  rspData;
  logic         memReqValid;
  logic         memReqReady = 1'b1;
  logic [25:0]  memReqLine;
  logic [1:0]   memReqSlot;
  logic         memRspValid = 1'b0;
  logic [1:0]   memRspSlot = '0;
  logic [511:0] memRspData = '0;

  always #4 clk = ~clk;

  remote_line_prefetch_buf dut (
    .clk(clk), .rstN(rstN), .flush(flush),
    .ldValid(ldValid), .ldReady(ldReady), .ldAddr(ldAddr),
    .rspValid(rspValid), .rspData(rspData),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqLine(memReqLine), .memReqSlot(memReqSlot),
    .memRspValid(memRspValid), .memRspSlot(memRspSlot), .memRspData(memRspData)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // Memory model: LIFO answers (out of order), data stamped at request time
  int qLine [16];
  int qSlot [16];
  int qVer  [16];
  int qCnt = 0;
  int reqLog [64];
  int reqCount = 0;
  int ver = 0;
  bit hold = 1'b0;
  bit relReq = 1'b0;
  int relLine = 0;

  function automatic logic [31:0] mkWord(input int line, input int w, input int v);
    logic [31:0] lv, wv, vv;
    lv = 32'(line);
    wv = 32'(w);
    vv = 32'(v);
    return {vv[3:0], lv[19:0], 4'h0, wv[3:0]};
  endfunction

  function automatic logic [31:0] mkAddr(input int line, input int w);
    return (32'(line) << 6) | (32'(w) << 2);
  endfunction

  task automatic sendRsp(input int idx);
    memRspValid = 1'b1;
    memRspSlot  = 2'(qSlot[idx]);
    for (int w = 0; w < 16; w++) memRspData[w*32 +: 32] = mkWord(qLine[idx], w, qVer[idx]);
    for (int k = idx; k < qCnt - 1; k++) begin
      qLine[k] = qLine[k+1];
      qSlot[k] = qSlot[k+1];
      qVer[k]  = qVer[k+1];
    end
    qCnt--;
  endtask

  always @(negedge clk) begin
    memRspValid = 1'b0;
    if (rstN) begin
      if (relReq) begin
        for (int k = 0; k < qCnt; k++)
          if (relReq && qLine[k] == relLine) begin
            sendRsp(k);
            relReq = 1'b0;
          end
      end else if (!hold && qCnt > 0) begin
        sendRsp(qCnt - 1);
      end
      if (memReqValid && memReqReady && qCnt < 16) begin
        qLine[qCnt] = int'(memReqLine);
        qSlot[qCnt] = int'(memReqSlot);
        qVer[qCnt]  = ver;
        qCnt++;
        if (reqCount < 64) reqLog[reqCount] = int'(memReqLine);
        reqCount++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [31:0] ldData;
  bit          ldOk;
  bit          ldDone;

  task automatic doLoad(input logic [31:0] addr);
    ldDone = 1'b0;
    ldOk   = 1'b0;
    while (!ldReady) step();
    ldValid = 1'b1;
    ldAddr  = addr;
    step();
    ldValid = 1'b0;
    for (int t = 0; t < 600; t++) begin
      if (rspValid) begin
        ldData = rspData;
        ldOk   = 1'b1;
        break;
      end
      step();
    end
    ldDone = 1'b1;
  endtask

  task automatic waitReq(input int n);
    for (int t = 0; t < 600; t++) begin
      if (reqCount >= n) break;
      step();
    end
  endtask

  task automatic pulseFlush();
    flush = 1'b1;
    step();
    flush = 1'b0;
  endtask

  int base;

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();

    // R1 reset state
    chk(ldReady == 1'b1, "R1 ldReady", 32'(ldReady), 1);
    chk(memReqValid == 1'b0, "R1 memReqValid", 32'(memReqValid), 0);
    chk(rspValid == 1'b0, "R1 rspValid", 32'(rspValid), 0);

    // R2 miss: demand line then next line
    base = reqCount;
    doLoad(mkAddr(16, 3));
    chk(ldOk && ldData == mkWord(16, 3, 0), "R2 miss data", ldData, mkWord(16, 3, 0));
    chk(reqCount == base + 2, "R2 request count", 32'(reqCount - base), 2);
    chk(reqLog[base] == 16 && reqLog[base+1] == 17, "R2 request order",
        32'(reqLog[base+1]), 17);
    step();
    chk(rspValid == 1'b0, "R12 single pulse", 32'(rspValid), 0);

    // R3/R6 hit on prefetched line, only new prefetch requested
    base = reqCount;
    doLoad(mkAddr(17, 5));
    chk(ldOk && ldData == mkWord(17, 5, 0), "R3 prefetched hit data", ldData, mkWord(17, 5, 0));
    chk(reqCount == base + 1 && reqLog[base] == 18, "R6 only next line requested",
        32'(reqCount - base), 1);

    base = reqCount;
    doLoad(mkAddr(16, 0));
    chk(ldOk && ldData == mkWord(16, 0, 0), "R3 hit word 0", ldData, mkWord(16, 0, 0));
    chk(reqCount == base, "R3 no request on hit", 32'(reqCount - base), 0);

    // R7 replacement: empty first, then oldest
    base = reqCount;
    doLoad(mkAddr(40, 15));
    chk(ldOk && ldData == mkWord(40, 15, 0), "R7 data word 15", ldData, mkWord(40, 15, 0));
    chk(reqCount == base + 2, "R7 two requests", 32'(reqCount - base), 2);
    base = reqCount;
    doLoad(mkAddr(17, 1));
    chk(ldOk && ldData == mkWord(17, 1, 0), "R7 evicted line refetched", ldData, mkWord(17, 1, 0));
    chk(reqCount == base + 2 && reqLog[base] == 17 && reqLog[base+1] == 18,
        "R7 lru victims", 32'(reqCount - base), 2);
    base = reqCount;
    doLoad(mkAddr(40, 2));
    chk(ldOk && reqCount == base, "R7 recent line kept", 32'(reqCount - base), 0);

    // R8 stale data returned after memory change
    ver = 1;
    base = reqCount;
    doLoad(mkAddr(40, 9));
    chk(ldOk && ldData == mkWord(40, 9, 0), "R8 non-coherent data", ldData, mkWord(40, 9, 0));
    chk(reqCount == base, "R8 no refetch", 32'(reqCount - base), 0);

    // R9 flush invalidates everything
    pulseFlush();
    base = reqCount;
    doLoad(mkAddr(40, 9));
    chk(ldOk && ldData == mkWord(40, 9, 1), "R9 fresh data after flush", ldData, mkWord(40, 9, 1));
    chk(reqCount == base + 2 && reqLog[base] == 40, "R9 refetch after flush",
        32'(reqCount - base), 2);

    // R4/R5 load to a line still in flight, fills released out of order
    hold = 1'b1;
    base = reqCount;
    fork
      doLoad(mkAddr(60, 1));
      begin
        waitReq(base + 2);
        repeat (4) step();
        chk(!ldDone, "R4 waits for held fill", 32'(ldDone), 0);
        relLine = 60;
        relReq  = 1'b1;
      end
    join
    chk(ldOk && ldData == mkWord(60, 1, 1), "R5 fill by slot", ldData, mkWord(60, 1, 1));
    fork
      doLoad(mkAddr(61, 4));
      begin
        repeat (10) step();
        chk(reqCount == base + 3 && reqLog[base+2] == 62, "R4 no duplicate request",
            32'(reqCount - base), 3);
        chk(!ldDone, "R4 still waiting", 32'(ldDone), 0);
        hold = 1'b0;
      end
    join
    chk(ldOk && ldData == mkWord(61, 4, 1), "R4 data after fill", ldData, mkWord(61, 4, 1));
    chk(reqCount == base + 3, "R4 request total", 32'(reqCount - base), 3);

    // R10/R11 flush with fills outstanding, then all blocks waiting
    repeat (4) step();
    hold = 1'b1;
    base = reqCount;
    fork
      doLoad(mkAddr(80, 2));
      begin
        waitReq(base + 2);
        ver = 2;
        pulseFlush();
        waitReq(base + 4);
        ver = 3;
        pulseFlush();
        repeat (12) step();
        chk(reqCount == base + 4, "R11 stall without request", 32'(reqCount - base), 4);
        chk(!ldDone, "R11 load stalled", 32'(ldDone), 0);
        hold = 1'b0;
      end
    join
    chk(ldOk && ldData == mkWord(80, 2, 3), "R10 stale fills discarded", ldData, mkWord(80, 2, 3));
    chk(reqCount == base + 6 && reqLog[base+4] == 80, "R10 restart requests",
        32'(reqCount - base), 6);

    repeat (4) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule